// File: doc/BRIEF.md
# Dual-Channel Transmit Ready and Threshold Interrupt Unit

This block sits beside the two transmit FIFOs of a two-channel serial peripheral. It keeps a free-entry count for each 64-entry FIFO. The count falls on every accepted host write and rises on every accepted serializer pop. From that count it derives an active-low DMA request per channel. In the hysteresis mode the request goes inactive only when the FIFO is completely full. It comes back only once the programmed number of free entries exists again. In the simple mode the request is active only while the FIFO is empty.

Both ready states are mirrored into a two-bit status word. Per channel, a threshold interrupt fires when the space threshold is regained after the FIFO has been full. The interrupt identification byte shows a pending code until the host reads it. The read clears the interrupt.

Each channel is built from the same three pieces:

- a space counter;
- a ready state machine with states `RDY_OPEN` and `RDY_BLOCKED`;
- an interrupt state machine with states `IRQ_IDLE`, `IRQ_ARMED` and `IRQ_PENDING`.

Ready state machine transitions:

- In hysteresis mode, `RDY_OPEN` moves to `RDY_BLOCKED` when the next count is zero ("fill").
- In hysteresis mode, `RDY_BLOCKED` moves to `RDY_OPEN` when the next count reaches the threshold ("refill").
- In simple mode, the state is `RDY_OPEN` exactly when the next count equals the depth.

Interrupt state machine transitions:

- "arm": `IRQ_IDLE` moves to `IRQ_ARMED` when the next count is zero.
- "fire": `IRQ_ARMED` moves to `IRQ_PENDING` when the next count reaches the threshold.
- "ack": `IRQ_PENDING` moves to `IRQ_IDLE` on an identification read. It moves to `IRQ_ARMED` instead if the FIFO is full in that same cycle.

A threshold setting of 0 acts as 1, and a setting above the depth acts as the depth.

Top module: `txdma_ready_top`

## Requirements
- R1: After reset both free counts read 64, both ready outputs are low (active), the status word reads 2'b11, both interrupts are low and both identification bytes read 0x01.
- R2: Each accepted write lowers the channel's free count by one and each accepted pop raises it by one; a pop while the count is 64 is ignored and the count stays 64.
- R3: A write while the free count is 0 (and no pop) is dropped: the count stays 0.
- R4: A write and a pop in the same cycle leave the free count unchanged, including when the FIFO is full.
- R5: With mode_sel=1, the ready output goes high on the clock edge at which the count becomes 0 and stays low while at least one entry is free.
- R6: With mode_sel=1, once high the ready output stays high while the count is below the channel threshold and returns low on the edge at which the count reaches it; a count that falls below the threshold without reaching 0 does not raise it.
- R7: With mode_sel=0, the ready output is low exactly when the free count is 64.
- R8: Status bit 0 is the inverse of channel A's ready output and bit 1 the inverse of channel B's (1 = ready).
- R9: A channel's interrupt rises on the edge at which its count reaches its threshold after having been 0, and its identification byte then reads 0x02.
- R10: An identification read strobe while pending drops the interrupt at the next edge and the byte reads 0x01; reaching the threshold without an intervening full FIFO raises no interrupt.
- R11: The channels are independent: activity, threshold and interrupt of one never change the other's count, ready output or interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_sel | input | 1 | 1 = hysteresis request mode, 0 = request only when empty |
| wr_a | input | 1 | Host write strobe, channel A |
| wr_b | input | 1 | Host write strobe, channel B |
| pop_a | input | 1 | Serializer pop strobe, channel A |
| pop_b | input | 1 | Serializer pop strobe, channel B |
| thr_a | input | 7 | Free-space threshold, channel A |
| thr_b | input | 7 | Free-space threshold, channel B |
| iir_rd_a | input | 1 | Identification read strobe, channel A |
| iir_rd_b | input | 1 | Identification read strobe, channel B |
| free_a | output | 7 | Free entries, channel A |
| free_b | output | 7 | Free entries, channel B |
| txrdy_n_a | output | 1 | Active-low DMA transmit request, channel A |
| txrdy_n_b | output | 1 | Active-low DMA transmit request, channel B |
| rdy_status | output | 2 | Ready mirror, bit 0 = A, bit 1 = B |
| irq_a | output | 1 | Threshold interrupt, channel A |
| irq_b | output | 1 | Threshold interrupt, channel B |
| iir_a | output | 8 | Identification byte, channel A |
| iir_b | output | 8 | Identification byte, channel B |

## Verification
Channel A runs through a few writes and pops, then a complete fill and a refill pop by pop. The ready output is sampled one entry short of full, at full, one below the threshold and at the threshold. This separates full-only blocking from threshold blocking. A write/pop pair and a write past full distinguish dropped strobes from miscounted ones.

After the interrupt is acknowledged, the count is taken back down to just below the threshold and up again without a full FIFO. This shows that the interrupt needs a fill first. Channel B uses a different threshold while A sits idle, which separates per-channel thresholds from shared ones. Switching to the simple mode checks that the request follows only the empty condition.

// File: rtl/txdma_pkg.sv
package txdma_pkg;

    typedef enum logic {
        RDY_OPEN    = 1'b0,
        RDY_BLOCKED = 1'b1
    } rdy_state_e;

    typedef enum logic [1:0] {
        IRQ_IDLE    = 2'd0,
        IRQ_ARMED   = 2'd1,
        IRQ_PENDING = 2'd2
    } irq_state_e;

    localparam logic [7:0] IIR_CODE_PENDING = 8'h02;
    localparam logic [7:0] IIR_CODE_NONE    = 8'h01;

endpackage

// File: rtl/txdma_space_ctr.sv
module txdma_space_ctr #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             pop,
    output logic [CNT_W-1:0] free_q,
    output logic [CNT_W-1:0] free_nxt
);

    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

    logic take_wr;
    logic take_pop;

    always_comb begin
        take_wr  = wr && !pop && (free_q != '0);
        take_pop = pop && !wr && (free_q != FULL_FREE);
        free_nxt = free_q;
        if (take_wr) begin
            free_nxt = free_q - 1'b1;
        end else if (take_pop) begin
            free_nxt = free_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            free_q <= FULL_FREE;
        end else begin
            free_q <= free_nxt;
        end
    end

    AST_FREE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        free_q <= FULL_FREE) else $error("free count out of range"); // R2

    AST_FULL_WR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q == '0 && wr && !pop) |=> (free_q == '0)) else $error("write to full changed count"); // R3

    AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && pop) |=> $stable(free_q)) else $error("write+pop changed count"); // R4

endmodule

// File: rtl/txdma_ready_fsm.sv
module txdma_ready_fsm
    import txdma_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic [CNT_W-1:0] free_nxt,
    input  logic [CNT_W-1:0] thr_eff,
    output logic             txrdy_n
);

    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

    rdy_state_e state_q;
    rdy_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (!mode_sel) begin
            state_d = (free_nxt == FULL_FREE) ? RDY_OPEN : RDY_BLOCKED;
        end else begin
            unique case (state_q)
                RDY_OPEN:    if (free_nxt == '0)      state_d = RDY_BLOCKED;
                RDY_BLOCKED: if (free_nxt >= thr_eff) state_d = RDY_OPEN;
                default:     state_d = RDY_OPEN;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RDY_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        txrdy_n = (state_q == RDY_BLOCKED);
    end

    AST_BLOCK_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && free_nxt == '0) |=> txrdy_n) else $error("request not withdrawn at full"); // R5

    AST_HOLD_BELOW_THR: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && txrdy_n && free_nxt < thr_eff) |=> txrdy_n) else $error("request back below threshold"); // R6

    AST_SIMPLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> (txrdy_n == ($past(free_nxt) != FULL_FREE))) else $error("simple mode mismatch"); // R7

endmodule

// File: rtl/txdma_irq_fsm.sv
module txdma_irq_fsm
    import txdma_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iir_rd,
    input  logic [CNT_W-1:0] free_nxt,
    input  logic [CNT_W-1:0] thr_eff,
    output logic             irq,
    output logic [7:0]       iir
);

    irq_state_e state_q;
    irq_state_e state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:    if (free_nxt == '0)      state_d = IRQ_ARMED;
            IRQ_ARMED:   if (free_nxt >= thr_eff) state_d = IRQ_PENDING;
            IRQ_PENDING: if (iir_rd) state_d = (free_nxt == '0) ? IRQ_ARMED : IRQ_IDLE;
            default:     state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        irq = (state_q == IRQ_PENDING);
        iir = irq ? IIR_CODE_PENDING : IIR_CODE_NONE;
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && iir_rd) |=> !irq) else $error("read did not clear interrupt"); // R10

    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !iir_rd) |=> irq) else $error("interrupt dropped without read"); // R9

endmodule

// File: rtl/txdma_channel.sv
module txdma_channel #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             wr,
    input  logic             pop,
    input  logic [CNT_W-1:0] thr,
    input  logic             iir_rd,
    output logic [CNT_W-1:0] free_q,
    output logic             txrdy_n,
    output logic             irq,
    output logic [7:0]       iir
);

    localparam logic [CNT_W-1:0] FULL_FREE = CNT_W'(DEPTH);

    logic [CNT_W-1:0] free_nxt;
    logic [CNT_W-1:0] thr_eff;

    always_comb begin
        if (thr == '0) begin
            thr_eff = CNT_W'(1);
        end else if (thr > FULL_FREE) begin
            thr_eff = FULL_FREE;
        end else begin
            thr_eff = thr;
        end
    end

    txdma_space_ctr #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (wr),
        .pop      (pop),
        .free_q   (free_q),
        .free_nxt (free_nxt)
    );

    txdma_ready_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_rdy (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .free_nxt (free_nxt),
        .thr_eff  (thr_eff),
        .txrdy_n  (txrdy_n)
    );

    txdma_irq_fsm #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .iir_rd   (iir_rd),
        .free_nxt (free_nxt),
        .thr_eff  (thr_eff),
        .irq      (irq),
        .iir      (iir)
    );

    AST_IRQ_AT_THR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (free_q >= thr_eff)) else $error("interrupt below threshold"); // R9

    AST_RDY_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        (free_q == '0) |-> txrdy_n) else $error("request active with no space"); // R5

endmodule

// File: rtl/txdma_ready_top.sv
module txdma_ready_top #(
    parameter int DEPTH = 64,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic             wr_a,
    input  logic             wr_b,
    input  logic             pop_a,
    input  logic             pop_b,
    input  logic [CNT_W-1:0] thr_a,
    input  logic [CNT_W-1:0] thr_b,
    input  logic             iir_rd_a,
    input  logic             iir_rd_b,
    output logic [CNT_W-1:0] free_a,
    output logic [CNT_W-1:0] free_b,
    output logic             txrdy_n_a,
    output logic             txrdy_n_b,
    output logic [1:0]       rdy_status,
    output logic             irq_a,
    output logic             irq_b,
    output logic [7:0]       iir_a,
    output logic [7:0]       iir_b
);

    localparam int NCH = 2;

    logic [NCH-1:0]   wr_v;
    logic [NCH-1:0]   pop_v;
    logic [NCH-1:0]   rd_v;
    logic [CNT_W-1:0] thr_v  [NCH];
    logic [CNT_W-1:0] free_v [NCH];
    logic [NCH-1:0]   rdyn_v;
    logic [NCH-1:0]   irq_v;
    logic [7:0]       iir_v  [NCH];

    assign wr_v     = {wr_b, wr_a};
    assign pop_v    = {pop_b, pop_a};
    assign rd_v     = {iir_rd_b, iir_rd_a};
    assign thr_v[0] = thr_a;
    assign thr_v[1] = thr_b;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        txdma_channel #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .mode_sel (mode_sel),
            .wr       (wr_v[ch]),
            .pop      (pop_v[ch]),
            .thr      (thr_v[ch]),
            .iir_rd   (rd_v[ch]),
            .free_q   (free_v[ch]),
            .txrdy_n  (rdyn_v[ch]),
            .irq      (irq_v[ch]),
            .iir      (iir_v[ch])
        );
    end

    assign free_a     = free_v[0];
    assign free_b     = free_v[1];
    assign txrdy_n_a  = rdyn_v[0];
    assign txrdy_n_b  = rdyn_v[1];
    assign rdy_status = ~rdyn_v;
    assign irq_a      = irq_v[0];
    assign irq_b      = irq_v[1];
    assign iir_a      = iir_v[0];
    assign iir_b      = iir_v[1];

    AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy_status[0] != txrdy_n_a) && (rdy_status[1] != txrdy_n_b)) else $error("status mirror broken"); // R8

    AST_CH_ISOLATION: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_b && !pop_b) |=> $stable(free_b)) else $error("channel B count moved without B strobes"); // R11

endmodule

// File: tb/tb_txdma_ready_top.sv
`timescale 1ns/1ps
module tb_txdma_ready_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_sel = 1'b1;
    logic       wr_a = 1'b0, wr_b = 1'b0, pop_a = 1'b0, pop_b = 1'b0;
    logic       iir_rd_a = 1'b0, iir_rd_b = 1'b0;
    logic [6:0] thr_a = 7'd8, thr_b = 7'd20;
    logic [6:0] free_a, free_b;
    logic       txrdy_n_a, txrdy_n_b, irq_a, irq_b;
    logic [1:0] rdy_status;
    logic [7:0] iir_a, iir_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    txdma_ready_top dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel),
        .wr_a(wr_a), .wr_b(wr_b), .pop_a(pop_a), .pop_b(pop_b),
        .thr_a(thr_a), .thr_b(thr_b), .iir_rd_a(iir_rd_a), .iir_rd_b(iir_rd_b),
        .free_a(free_a), .free_b(free_b), .txrdy_n_a(txrdy_n_a), .txrdy_n_b(txrdy_n_b),
        .rdy_status(rdy_status), .irq_a(irq_a), .irq_b(irq_b), .iir_a(iir_a), .iir_b(iir_b)
    );

    task automatic chk(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Called at a falling edge; drives strobes for one rising edge and returns at the next falling edge.
    task automatic run(int n, bit wa, bit wb, bit pa, bit pb, bit ra, bit rb);
        for (int i = 0; i < n; i++) begin
            wr_a = wa; wr_b = wb; pop_a = pa; pop_b = pb; iir_rd_a = ra; iir_rd_b = rb;
            @(negedge clk);
        end
        wr_a = 0; wr_b = 0; pop_a = 0; pop_b = 0; iir_rd_a = 0; iir_rd_b = 0;
    endtask

    task automatic t_reset();
        chk("R1 free_a", free_a, 64);
        chk("R1 free_b", free_b, 64);
        chk("R1 txrdy_n_a", txrdy_n_a, 0);
        chk("R1 txrdy_n_b", txrdy_n_b, 0);
        chk("R1 status", rdy_status, 3);
        chk("R1 irq_a", irq_a, 0);
        chk("R1 irq_b", irq_b, 0);
        chk("R1 iir_a", iir_a, 1);
        chk("R1 iir_b", iir_b, 1);
    endtask

    task automatic t_basic();
        run(3, 1, 0, 0, 0, 0, 0);
        chk("R2 three writes", free_a, 61);
        run(2, 0, 0, 1, 0, 0, 0);
        chk("R2 two pops", free_a, 63);
        run(1, 0, 0, 1, 0, 0, 0);
        chk("R2 back to empty", free_a, 64);
        run(1, 0, 0, 1, 0, 0, 0);
        chk("R2 pop when empty ignored", free_a, 64);
        chk("R11 free_b untouched", free_b, 64);
    endtask

    task automatic t_fill();
        run(63, 1, 0, 0, 0, 0, 0);
        chk("R5 one free left", free_a, 1);
        chk("R5 still ready one short of full", txrdy_n_a, 0);
        run(1, 1, 0, 0, 0, 0, 0);
        chk("R5 full count", free_a, 0);
        chk("R5 request withdrawn at full", txrdy_n_a, 1);
        chk("R8 status A not ready", rdy_status, 2);
        run(1, 1, 0, 0, 0, 0, 0);
        chk("R3 write to full dropped", free_a, 0);
        run(1, 1, 0, 1, 0, 0, 0);
        chk("R4 pair at full", free_a, 0);
        chk("R9 no irq at full", irq_a, 0);
        chk("R11 B ready while A full", txrdy_n_b, 0);
    endtask

    task automatic t_hyst();
        run(7, 0, 0, 1, 0, 0, 0);
        chk("R6 count below threshold", free_a, 7);
        chk("R6 still blocked below threshold", txrdy_n_a, 1);
        chk("R9 no irq below threshold", irq_a, 0);
        run(1, 0, 0, 1, 0, 0, 0);
        chk("R6 count at threshold", free_a, 8);
        chk("R6 ready at threshold", txrdy_n_a, 0);
        chk("R9 irq at threshold", irq_a, 1);
        chk("R9 iir pending code", iir_a, 2);
        chk("R11 irq_b stays low", irq_b, 0);
    endtask

    task automatic t_ack();
        run(1, 1, 0, 1, 0, 0, 0);
        chk("R4 pair mid-fifo", free_a, 8);
        chk("R9 irq held without read", irq_a, 1);
        run(1, 0, 0, 0, 0, 1, 0);
        chk("R10 irq cleared by read", irq_a, 0);
        chk("R10 iir none code", iir_a, 1);
        run(1, 0, 0, 0, 0, 1, 0);
        chk("R10 second read none", iir_a, 1);
        run(1, 1, 0, 0, 0, 0, 0);
        chk("R6 below thr not full stays ready", txrdy_n_a, 0);
        run(1, 0, 0, 1, 0, 0, 0);
        chk("R10 threshold again no full", irq_a, 0);
    endtask

    task automatic t_chan_b();
        run(64, 0, 1, 0, 0, 0, 0);
        chk("R11 B full", free_b, 0);
        chk("R5 B request withdrawn", txrdy_n_b, 1);
        chk("R8 status B not ready", rdy_status, 1);
        chk("R11 A count kept", free_a, 8);
        run(19, 0, 0, 0, 1, 0, 0);
        chk("R11 B blocked below own threshold", txrdy_n_b, 1);
        run(1, 0, 0, 0, 1, 0, 0);
        chk("R11 B ready at own threshold", txrdy_n_b, 0);
        chk("R9 B irq", irq_b, 1);
        chk("R11 A irq stays low", irq_a, 0);
        run(1, 0, 0, 0, 0, 0, 1);
        chk("R10 B irq cleared", irq_b, 0);
    endtask

    task automatic t_simple();
        mode_sel = 1'b0;
        run(1, 0, 0, 0, 0, 0, 0);
        chk("R7 A not empty", txrdy_n_a, 1);
        chk("R7 B not empty", txrdy_n_b, 1);
        run(56, 0, 0, 1, 0, 0, 0);
        chk("R7 A empty count", free_a, 64);
        chk("R7 A ready when empty", txrdy_n_a, 0);
        run(1, 1, 0, 0, 0, 0, 0);
        chk("R7 A one byte written", txrdy_n_a, 1);
        run(44, 0, 0, 0, 1, 0, 0);
        chk("R7 B ready when empty", txrdy_n_b, 0);
        chk("R8 status", rdy_status, 2);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_fill();
        t_hyst();
        t_ack();
        t_chan_b();
        t_simple();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        #2_000_000;
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule